// File: doc/BRIEF.md
# Square-Wave Flow-Control Detector

This block sits on the transmit side of a serial link and decides, on every cycle of the local clock, whether the sender may put another word on the line. The receiver at the far end reports its state on a separate back channel as a square wave. A fast toggle means it has room. A slow toggle means its buffer is nearly full. That wave has no phase or frequency relationship to the local clock.

The detector brings the wave into the local clock domain through a chain of synchronizer flip-flops. It then measures how many consecutive sampled cycles the wave holds one level. Short runs allow transmission and long runs block it. The decision is a registered permit bit that drives the gate on the transmit path. The current run length is also brought out as an optional status value.

A line that never toggles, such as an unplugged cable, is never mistaken for a ready receiver. It simply holds the permit low.

Top module: `flowctl_run_decoder`

## Requirements
- R1: A level change on `fc_raw` that is present before a rising edge first changes `send_ok` and `run_len` at the third rising edge counted from that one, because it passes two synchronizer stages and one edge-detect register.
- R2: `run_len` is 1 in the cycle after a synchronized level change. It then grows by one for each further cycle in which the synchronized level stays the same.
- R3: While reset is asserted, and after its release until the first synchronized level change, `send_ok` is 0 and `run_len` equals `STOP_RUN`.
- R4: While the run length is 1, 2 or 3 (below `STOP_RUN`, default 4), `send_ok` is 1. A square wave whose level holds for 1, 2 or 3 clock cycles keeps the permit high continuously once locked.
- R5: On the cycle in which the run length reaches `STOP_RUN`, which is the fourth equal sample at the default, `send_ok` falls to 0.
- R6: With no transitions, `run_len` saturates at `STOP_RUN` and never wraps, and `send_ok` stays 0 indefinitely.
- R7: For a square wave at any phase and frequency unrelated to the clock, the permit always follows the run-length rule applied to the synchronized samples.
- R8: After a stop, `send_ok` returns to 1 in the same cycle in which the next synchronized level change is registered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock of the transmit path |
| rst_n | input | 1 | Asynchronous active-low reset |
| fc_raw | input | 1 | Flow-control square wave from the receiver, asynchronous |
| send_ok | output | 1 | Registered permit: 1 means the sender may transmit |
| run_len | output | RUN_W | Current run length, saturating at STOP_RUN; all zero when STATUS_EN is 0 |

## Verification
The hardest situation to reach is a wave edge that falls at an arbitrary fraction of a clock period, where the sampled run length lands right at the boundary between three and four. The bench drives asynchronous waves whose half-periods are not multiples of the clock period, using several different periods, so that the sampled runs step through the lengths 3, 4 and 5 in irregular patterns. The wave edges are kept on a picosecond grid that never coincides with a clock edge, which keeps the reference sampling unambiguous. A behavioural model built from the queue of sampled values is compared with both outputs on every cycle. Directed cases pin down the exact latency from a raw edge to the permit, and the exact cycle in which a run of four removes it.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

   // Bits needed to hold a run length that saturates at "limit".
   function automatic int run_width(input int limit);
      return $clog2(limit + 1);
   endfunction

endpackage

// File: rtl/fcd_sync.sv
module fcd_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout,
   output logic dvalid
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("fcd_sync: STAGES must be at least 2");
      end
   endgenerate

   // The data chain and a parallel validity chain. The validity chain marks
   // when dout holds a real sample rather than the reset value.
   logic [STAGES-1:0] data_q;
   logic [STAGES-1:0] vld_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0;
         vld_q  <= '0;
      end else begin
         data_q <= {data_q[STAGES-2:0], din};
         vld_q  <= {vld_q[STAGES-2:0], 1'b1};
      end
   end

   assign dout   = data_q[STAGES-1];
   assign dvalid = vld_q[STAGES-1];

endmodule

// File: rtl/fcd_run.sv
module fcd_run #(
   parameter int LIMIT = 4,
   parameter int W     = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         smp,
   input  logic         smp_vld,
   output logic         chg,
   output logic [W-1:0] run_q,
   output logic [W-1:0] run_nxt
);

   localparam logic [W-1:0] SAT = W'(LIMIT);
   localparam logic [W-1:0] ONE = W'(1);

   generate
      if (LIMIT < 2) begin : g_bad_limit
         $error("fcd_run: LIMIT must be at least 2");
      end
      if ((1 << W) <= LIMIT) begin : g_bad_width
         $error("fcd_run: W too narrow for LIMIT");
      end
   endgenerate

   logic prev_q;
   logic prev_vld_q;

   // A change only counts when both compared values are real samples.
   assign chg = smp_vld & prev_vld_q & (smp ^ prev_q);

   always_comb begin
      if (chg)
         run_nxt = ONE;
      else if (run_q == SAT)
         run_nxt = SAT;
      else
         run_nxt = run_q + ONE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q     <= 1'b0;
         prev_vld_q <= 1'b0;
         run_q      <= SAT;
      end else begin
         prev_q     <= smp;
         prev_vld_q <= smp_vld;
         run_q      <= run_nxt;
      end
   end

   assert_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_vld && prev_vld_q && (smp != prev_q)) |=> (run_q == ONE));

   assert_no_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q == SAT && !chg) |=> (run_q == SAT));

endmodule

// File: rtl/fcd_permit.sv
module fcd_permit #(
   parameter int LIMIT = 4,
   parameter int W     = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] run_nxt,
   output logic         ok
);

   localparam logic [W-1:0] SAT = W'(LIMIT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ok <= 1'b0;
      else
         ok <= (run_nxt < SAT);
   end

endmodule

// File: rtl/flowctl_run_decoder.sv
module flowctl_run_decoder #(
   parameter int SYNC_STAGES = 2,
   parameter int STOP_RUN    = 4,
   parameter bit STATUS_EN   = 1'b1,
   localparam int RUN_W      = fcd_pkg::run_width(STOP_RUN)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fc_raw,
   output logic             send_ok,
   output logic [RUN_W-1:0] run_len
);

   localparam logic [RUN_W-1:0] SAT = RUN_W'(STOP_RUN);

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("flowctl_run_decoder: SYNC_STAGES must be at least 2");
      end
      if (STOP_RUN < 2) begin : g_bad_stop
         $error("flowctl_run_decoder: STOP_RUN must be at least 2");
      end
   endgenerate

   logic             smp;
   logic             smp_vld;
   logic             chg;
   logic [RUN_W-1:0] run_q;
   logic [RUN_W-1:0] run_nxt;

   fcd_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .din    (fc_raw),
      .dout   (smp),
      .dvalid (smp_vld)
   );

   fcd_run #(.LIMIT(STOP_RUN), .W(RUN_W)) u_run (
      .clk     (clk),
      .rst_n   (rst_n),
      .smp     (smp),
      .smp_vld (smp_vld),
      .chg     (chg),
      .run_q   (run_q),
      .run_nxt (run_nxt)
   );

   fcd_permit #(.LIMIT(STOP_RUN), .W(RUN_W)) u_permit (
      .clk     (clk),
      .rst_n   (rst_n),
      .run_nxt (run_nxt),
      .ok      (send_ok)
   );

   generate
      if (STATUS_EN) begin : g_status
         assign run_len = run_q;
      end else begin : g_no_status
         assign run_len = '0;
      end
   endgenerate

   // The permit register and the run counter are separate flops; check that they agree.
   assert_permit_short_R4: assert property (@(posedge clk) disable iff (!rst_n)
      send_ok |-> (run_q < SAT));

   assert_stop_at_limit_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q == SAT - 1 && !chg) |=> !send_ok);

   assert_idle_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q == SAT) |-> !send_ok);

   assert_resume_R8: assert property (@(posedge clk) disable iff (!rst_n)
      chg |=> send_ok);

endmodule

// File: tb/flowctl_run_decoder_test.sv
`timescale 1ns/1ps
module flowctl_run_decoder_test;

   localparam int STOP = 4;
   localparam int W    = 3;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         fc_raw = 1'b0;
   logic         send_ok;
   logic [W-1:0] run_len;

   int    checks = 0;
   int    failures = 0;
   string tag = "R3";
   bit    done = 1'b0;
   bit    cmp_en = 1'b1;

   always #2.5 clk = ~clk;

   flowctl_run_decoder #(.SYNC_STAGES(2), .STOP_RUN(STOP), .STATUS_EN(1'b1)) uut (
      .clk     (clk),
      .rst_n   (rst_n),
      .fc_raw  (fc_raw),
      .send_ok (send_ok),
      .run_len (run_len)
   );

   // Reference model: the queue of raw values sampled at each rising edge since reset.
   bit q[$];
   int edges = 0;
   int m_run = STOP;
   bit m_ok = 1'b0;

   always @(posedge clk) begin
      if (!rst_n) begin
         q.delete();
         edges = 0;
         m_run = STOP;
         m_ok  = 1'b0;
      end else begin
         edges++;
         q.push_back(fc_raw);
         if (edges >= 4 && q[edges-3] != q[edges-4])
            m_run = 1;
         else if (m_run < STOP)
            m_run++;
         m_ok = (m_run < STOP);
      end
   end

   task automatic check(input bit cond, input string req, input int act, input int exp);
      checks++;
      if (!cond) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   // Per-cycle comparison with the model.
   always @(negedge clk) begin
      if (cmp_en && !done) begin
         check(send_ok == m_ok, {tag, " permit"}, int'(send_ok), int'(m_ok));
         check(int'(run_len) == m_run, {tag, " run_len"}, int'(run_len), m_run);
      end
   end

   task automatic square(input int half, input int cycles);
      for (int i = 0; i < cycles; i++) begin
         @(negedge clk);
         if (i % half == 0) fc_raw = ~fc_raw;
      end
   endtask

   // Edges land on a grid of 10 ps plus 5 ps, so they never meet a clock edge.
   task automatic async_wave(input real half_ns, input int toggles);
      @(negedge clk);
      #1.305;
      for (int i = 0; i < toggles; i++) begin
         fc_raw = ~fc_raw;
         #(half_ns);
      end
      @(negedge clk);
   endtask

   int low_cnt;

   initial begin
      // R3: reset state.
      tag = "R3";
      repeat (3) @(negedge clk);
      check(send_ok == 1'b0, "R3 reset permit", int'(send_ok), 0);
      check(int'(run_len) == STOP, "R3 reset run_len", int'(run_len), STOP);
      rst_n = 1'b1;

      // R6: a quiet line stays blocked and the counter does not wrap.
      tag = "R6";
      repeat (30) @(negedge clk);
      check(send_ok == 1'b0, "R6 quiet line permit", int'(send_ok), 0);
      check(int'(run_len) == STOP, "R6 saturated run_len", int'(run_len), STOP);

      // R1, R8, R2, R5: single toggle from a stopped state.
      tag = "R1";
      @(negedge clk);
      fc_raw = ~fc_raw;
      @(negedge clk);
      check(send_ok == 1'b0, "R1 after edge 1", int'(send_ok), 0);
      @(negedge clk);
      check(send_ok == 1'b0, "R1 after edge 2", int'(send_ok), 0);
      @(negedge clk);
      check(send_ok == 1'b1, "R1 R8 after edge 3", int'(send_ok), 1);
      check(int'(run_len) == 1, "R2 restart at one", int'(run_len), 1);
      @(negedge clk);
      check(int'(run_len) == 2, "R2 count up", int'(run_len), 2);
      @(negedge clk);
      check(send_ok == 1'b1, "R4 run of three", int'(send_ok), 1);
      @(negedge clk);
      check(send_ok == 1'b0, "R5 fourth equal sample", int'(send_ok), 0);
      check(int'(run_len) == STOP, "R5 run_len at limit", int'(run_len), STOP);

      // R4: fast waves keep the permit high once locked.
      for (int h = 1; h <= 3; h++) begin
         tag = "R4";
         square(h, 6);
         low_cnt = 0;
         for (int c = 0; c < 24; c++) begin
            @(negedge clk);
            if (c % h == 0) fc_raw = ~fc_raw;
            if (!send_ok) low_cnt++;
         end
         check(low_cnt == 0, "R4 permit held for short runs", low_cnt, 0);
      end

      // R5: a slow wave produces stop cycles.
      tag = "R5";
      low_cnt = 0;
      for (int c = 0; c < 40; c++) begin
         @(negedge clk);
         if (c % 4 == 0) fc_raw = ~fc_raw;
         if (!send_ok) low_cnt++;
      end
      check(low_cnt >= 8, "R5 half-period four blocks", low_cnt, 10);
      square(5, 30);
      square(8, 40);

      // R7: asynchronous waves of unrelated periods.
      tag = "R7";
      async_wave(3.71, 60);
      async_wave(13.33, 40);
      async_wave(17.27, 40);
      async_wave(21.43, 30);
      async_wave(7.79, 50);

      // R3: a mid-run reset returns to the blocked state.
      tag = "R3";
      square(1, 10);
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      check(send_ok == 1'b0, "R3 reset during traffic", int'(send_ok), 0);
      @(negedge clk);
      rst_n = 1'b1;
      tag = "R6";
      repeat (12) @(negedge clk);
      check(send_ok == 1'b0, "R6 quiet after reset", int'(send_ok), 0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         failures++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule